// File: doc/BRIEF.md
# Triangle-Wave Dither Offset Generator

This block drives the frequency-offset input of a spread-spectrum clock source. It runs on the master clock and produces a signed offset word in units of 1/1024 of the centre frequency. While dithering is on, the word follows a triangle: it rises from zero to a positive peak, falls through zero to the matching negative peak, and climbs back to zero. This repeats once per modulation period. Because the swing is symmetric, the mean frequency stays at the undithered centre for every amplitude setting. A downstream numerically controlled oscillator applies the word to its phase increment, so duty cycle is left to that oscillator and the offset does not affect it.

A 2-bit rate code picks the modulation period as a power-of-two multiple of the master clock. A 2-bit amplitude code picks the peak deviation, from 1% to 8% of the centre. Dithering runs only while the enable pin is high and the rate code is nonzero. The ramp advances one unit at a time. A Bresenham-style accumulator spaces the unit steps so that each period lasts exactly the selected number of master cycles, even when that number does not divide evenly by the step count.

Top module: `dith_tri_gen`

## Requirements
- R1: During and right after a synchronous active-low reset, `offset` is 0 and `dith_on` is 0.
- R2: When `dith_en` is 0, or `rate_sel` is 00, `offset` is 0 and `dith_on` is 0 from the next clock edge on, for as long as the condition lasts.
- R3: The peak magnitude is 10, 20, 41 or 82 units for `amp_sel` 00, 01, 10 or 11 (1%, 2%, 4%, 8% of 1024, rounded). The offset never goes beyond plus or minus that peak.
- R4: The modulation period is exactly 2048, 4096 or 8192 master cycles for `rate_sel` 01, 10 or 11.
- R5: Count t as the edges after the restart edge. The offset is +peak at t = P/4, 0 at t = P/2, -peak at t = 3P/4 and 0 again at t = P, where P is the period. The waveform is therefore centred on zero.
- R6: From one cycle to the next the offset changes by exactly one unit on a step and stays unchanged otherwise.
- R7: A change of `rate_sel` or `amp_sel` restarts the ramp. On the first edge that sees the new code, the offset goes to 0. The next step after that is +1.
- R8: `dith_on` is 1 one edge after `dith_en` is 1 with a nonzero rate code, and stays 1 while that condition holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dith_en | input | 1 | Dither enable pin |
| rate_sel | input | 2 | Modulation period code (00 = off) |
| amp_sel | input | 2 | Peak deviation code |
| offset | output | 8 | Signed offset, units of 1/1024 of centre frequency |
| dith_on | output | 1 | Dithering is running |

## Verification
The bench goes after the phase points of the ramp, for all twelve code pairs. If the accumulator drops its remainder, the period stretches and the peak arrives late. If the turnaround has an off-by-one error, the offset overshoots the peak or the waveform spends an extra step at the top, which moves the zero crossing away from P/2. The bench also changes codes and drops the enable in mid-ramp, to catch a design that keeps its old phase or direction. Such a design would resume away from zero, or go downward after a restart.

// File: rtl/dith_pkg.sv
// Package: shared codes and the amplitude rounding used by the dither
// generator. Assumes percentages are whole numbers of the base step.
package dith_pkg;

    typedef enum logic [1:0] {
        RATE_OFF = 2'b00,
        RATE_X1  = 2'b01,
        RATE_X2  = 2'b10,
        RATE_X4  = 2'b11
    } rate_code_e;

    // Peak in units of 1/den, for base_pct percent times 2^code, rounded.
    function automatic int peak_units(input int den, input int base_pct, input int code);
        return (den * base_pct * (1 << code) + 50) / 100;
    endfunction

endpackage

// File: rtl/dith_cfg.sv
// Module: decodes rate and amplitude codes into period, peak and step
// stride, and flags a code change so the ramp restarts. Assumes codes
// may change in any cycle; the change is seen one edge later.
module dith_cfg #(
    parameter int BASE_LOG = 11,
    parameter int ACC_W    = BASE_LOG + 3,
    parameter int PK_W     = 7,
    parameter int FRAC_DEN = 1024,
    parameter int BASE_PCT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       rate,
    input  logic [1:0]       amp,
    output logic             run,
    output logic             active,
    output logic [ACC_W-1:0] period,
    output logic [ACC_W-1:0] stride,
    output logic [PK_W-1:0]  peak
);
    import dith_pkg::*;

    localparam int N_AMP = 4;

    logic [1:0]      prev_rate;
    logic [1:0]      prev_amp;
    logic            act_q;
    logic            want;
    logic            changed;
    logic [PK_W-1:0] pk_tab [N_AMP];

    // Build the peak table, one entry per amplitude code.
    for (genvar g = 0; g < N_AMP; g++) begin : g_peak
        assign pk_tab[g] = PK_W'(peak_units(FRAC_DEN, BASE_PCT, g));
    end

    // Request and change detection.
    always_comb begin
        want    = en && (rate_code_e'(rate) != RATE_OFF);
        changed = (rate != prev_rate) || (amp != prev_amp);
        run     = want && !changed;
    end

    // Remember the last codes seen and the running state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_rate <= 2'b00;
            prev_amp  <= 2'b00;
            act_q     <= 1'b0;
        end else begin
            prev_rate <= rate;
            prev_amp  <= amp;
            act_q     <= want;
        end
    end

    // Period selection from the rate code.
    always_comb begin
        case (rate_code_e'(rate))
            RATE_X1: period = ACC_W'(1) << BASE_LOG;
            RATE_X2: period = ACC_W'(1) << (BASE_LOG + 1);
            RATE_X4: period = ACC_W'(1) << (BASE_LOG + 2);
            default: period = ACC_W'(1) << BASE_LOG;
        endcase
    end

    // Peak and the four-ramp step count per period.
    always_comb begin
        peak   = pk_tab[amp];
        stride = ACC_W'(peak) << 2;
    end

    assign active = act_q;

endmodule

// File: rtl/dith_pacer.sv
// Module: spreads 'stride' unit steps evenly over 'period' cycles with a
// remainder accumulator. Assumes stride < period. Clears when not running.
module dith_pacer #(
    parameter int ACC_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [ACC_W-1:0] period,
    input  logic [ACC_W-1:0] stride,
    output logic             tick
);
    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] sum;

    // Next accumulator sum and step decision.
    always_comb begin
        sum  = acc + stride;
        tick = run && (sum >= period);
    end

    // Accumulate; wrap by one period on each step.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            acc <= '0;
        end else if (tick) begin
            acc <= sum - period;
        end else begin
            acc <= sum;
        end
    end

    // R4: remainder stays below one period while running.
    p_acc_below_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (acc < period));

endmodule

// File: rtl/dith_ramp.sv
// Module: up/down counter that turns at +peak and -peak. Restarts at zero,
// heading up, whenever run is low. Assumes peak stays fixed while running.
module dith_ramp #(
    parameter int OFS_W = 8,
    parameter int PK_W  = OFS_W - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    tick,
    input  logic [PK_W-1:0]         peak,
    output logic signed [OFS_W-1:0] ofs
);
    logic                    up;
    logic signed [OFS_W-1:0] pk_s;
    logic signed [OFS_W-1:0] inc;
    logic signed [OFS_W-1:0] dec;

    // Signed peak and neighbour values.
    always_comb begin
        pk_s = $signed({{(OFS_W-PK_W){1'b0}}, peak});
        inc  = ofs + OFS_W'(1);
        dec  = ofs - OFS_W'(1);
    end

    // Move one unit per tick and turn at the extremes.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            ofs <= '0;
            up  <= 1'b1;
        end else if (tick) begin
            if (up) begin
                ofs <= inc;
                if (inc == pk_s) up <= 1'b0;
            end else begin
                ofs <= dec;
                if (dec == -pk_s) up <= 1'b1;
            end
        end
    end

    // R3: offset bounded by the selected peak while running.
    p_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (ofs <= pk_s && ofs >= -pk_s));

    // R6: a step moves exactly one unit.
    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick) |=> (ofs == $past(ofs) + OFS_W'(1) || ofs == $past(ofs) - OFS_W'(1)));

    // R6: no step means no movement.
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !tick) |=> $stable(ofs));

endmodule

// File: rtl/dith_tri_gen.sv
// Module: top of the triangle dither offset generator. Joins decode, pacer
// and ramp. Assumes all inputs are synchronous to clk.
module dith_tri_gen #(
    parameter int OFS_W    = 8,
    parameter int BASE_LOG = 11,
    parameter int FRAC_DEN = 1024,
    parameter int BASE_PCT = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    dith_en,
    input  logic [1:0]              rate_sel,
    input  logic [1:0]              amp_sel,
    output logic signed [OFS_W-1:0] offset,
    output logic                    dith_on
);
    localparam int ACC_W = BASE_LOG + 3;
    localparam int PK_W  = OFS_W - 1;

    logic             run;
    logic             tick;
    logic [ACC_W-1:0] period;
    logic [ACC_W-1:0] stride;
    logic [PK_W-1:0]  peak;

    dith_cfg #(
        .BASE_LOG (BASE_LOG),
        .ACC_W    (ACC_W),
        .PK_W     (PK_W),
        .FRAC_DEN (FRAC_DEN),
        .BASE_PCT (BASE_PCT)
    ) i_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (dith_en),
        .rate   (rate_sel),
        .amp    (amp_sel),
        .run    (run),
        .active (dith_on),
        .period (period),
        .stride (stride),
        .peak   (peak)
    );

    dith_pacer #(.ACC_W(ACC_W)) i_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .period (period),
        .stride (stride),
        .tick   (tick)
    );

    dith_ramp #(.OFS_W(OFS_W), .PK_W(PK_W)) i_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick),
        .peak  (peak),
        .ofs   (offset)
    );

    // R2: disabled request forces zero and idle on the next edge.
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(dith_en && rate_sel != 2'b00) |=> (offset == '0 && !dith_on));

    // R7: a code change clears the offset on the next edge.
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel != $past(rate_sel) || amp_sel != $past(amp_sel)) |=> (offset == '0));

    // R8: a valid request raises the running flag one edge later.
    p_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dith_en && rate_sel != 2'b00) |=> dith_on);

endmodule

// File: tb/test_dith_tri_gen.sv
module test_dith_tri_gen;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dith_en = 1'b0;
    logic [1:0]        rate_sel = 2'b00;
    logic [1:0]        amp_sel = 2'b00;
    logic signed [7:0] offset;
    logic              dith_on;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    dith_tri_gen i_dith_tri_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .dith_en  (dith_en),
        .rate_sel (rate_sel),
        .amp_sel  (amp_sel),
        .offset   (offset),
        .dith_on  (dith_on)
    );

    // rate, amp, expected peak, expected period
    localparam int N_VEC = 12;
    localparam int VEC [N_VEC][4] = '{
        '{1, 0, 10, 2048}, '{1, 1, 20, 2048}, '{1, 2, 41, 2048}, '{1, 3, 82, 2048},
        '{2, 0, 10, 4096}, '{2, 1, 20, 4096}, '{2, 2, 41, 4096}, '{2, 3, 82, 4096},
        '{3, 0, 10, 8192}, '{3, 1, 20, 8192}, '{3, 2, 41, 8192}, '{3, 3, 82, 8192}
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v;
        int prev;
        int vmax;
        int vmin;
        int t1;
        int t2;
        int jumps;
        int first_nz;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 offset in reset", offset, 0);
        chk("R1 dith_on in reset", dith_on, 0);
        dith_en = 1'b1;
        rate_sel = 2'd1;
        @(negedge clk);
        chk("R1 offset held by reset", offset, 0);
        rst_n = 1'b1;

        // Table walk: R3, R4, R5, R6
        for (int e = 0; e < N_VEC; e++) begin
            int p;
            int pk;
            p  = VEC[e][3];
            pk = VEC[e][2];
            @(negedge clk);
            rate_sel = 2'(VEC[e][0]);
            amp_sel  = 2'(VEC[e][1]);
            @(negedge clk);
            chk("R7 zero after code change", offset, 0);
            prev = 0; vmax = 0; vmin = 0; t1 = -1; t2 = -1; jumps = 0;
            for (int t = 1; t <= p + p / 4; t++) begin
                @(negedge clk);
                v = offset;
                if (t <= p) begin
                    if (v > vmax) vmax = v;
                    if (v < vmin) vmin = v;
                end
                if (v - prev > 1 || prev - v > 1) jumps++;
                if (v == 1 && prev == 0) begin
                    if (t1 < 0) t1 = t;
                    else if (t2 < 0) t2 = t;
                end
                if (t == p / 4)     chk("R5 +peak at P/4", v, pk);
                if (t == p / 2)     chk("R5 zero at P/2", v, 0);
                if (t == 3 * p / 4) chk("R5 -peak at 3P/4", v, -pk);
                if (t == p)         chk("R5 zero at P", v, 0);
                prev = v;
                if (t >= p && t2 >= 0) break;
            end
            chk("R3 max offset", vmax, pk);
            chk("R3 min offset", vmin, -pk);
            chk("R4 period", t2 - t1, p);
            chk("R6 unit steps", jumps, 0);
            chk("R8 dith_on running", dith_on, 1);
        end

        // R2: enable dropped mid-ramp
        rate_sel = 2'd1;
        amp_sel  = 2'd3;
        repeat (300) @(negedge clk);
        dith_en = 1'b0;
        @(negedge clk);
        chk("R2 zero after enable low", offset, 0);
        chk("R2 dith_on after enable low", dith_on, 0);
        jumps = 0;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (offset != 0) jumps++;
        end
        chk("R2 stays zero while disabled", jumps, 0);

        // R8: re-enable
        dith_en = 1'b1;
        @(negedge clk);
        chk("R8 dith_on after enable", dith_on, 1);

        // R2: rate code 00 with enable high
        repeat (300) @(negedge clk);
        rate_sel = 2'd0;
        @(negedge clk);
        chk("R2 zero with rate 00", offset, 0);
        chk("R2 dith_on with rate 00", dith_on, 0);
        repeat (100) @(negedge clk);
        chk("R2 still zero with rate 00", offset, 0);

        // R7: amplitude change mid-fall restarts rising from zero
        rate_sel = 2'd1;
        amp_sel  = 2'd1;
        repeat (1024 + 100) @(negedge clk);
        chk("R7 ramp in negative half", (offset < 0) ? 1 : 0, 1);
        amp_sel = 2'd2;
        @(negedge clk);
        chk("R7 zero after amp change", offset, 0);
        first_nz = 0;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (first_nz == 0 && offset != 0) first_nz = offset;
        end
        chk("R7 first step is +1", first_nz, 1);

        // R1: reset mid-ramp
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 offset after mid-ramp reset", offset, 0);
        chk("R1 dith_on after mid-ramp reset", dith_on, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule